// File: doc/BRIEF.md
# Two-Wire Command Slave for an Eight-Channel Converter

This block is the serial front of a multi-channel 12-bit acquisition system. It watches an oversampled two-wire bus (clock and open-drain data), recognises START and STOP, and answers one 7-bit address. The upper four address bits are a fixed pattern; the lower three come from strap inputs, so eight copies can share one bus.

A write carries one command byte. The command is framed by its own leading 1: zero bits sent before that 1 are skipped. The byte selects the channel, the span, unipolar or bipolar coding, and the power-down mode. As soon as the polarity bit has been sampled, the block pulses an acquisition strobe to the converter core. The STOP that closes the write pulses the conversion strobe. A read returns the 12-bit result left-justified in two bytes. The result is captured when the read address is accepted. The master's acknowledge bits during a read are not acted on.

Top module: `adc_cmd_slave`

## Requirements
- R1: After reset, `sdaOe` is 0, every command output is 0 (channel 0, low span, unipolar, power-down mode 00) and neither strobe pulses.
- R2: An address byte whose seven bits equal {0101, addrStrap[2:0]}, followed by a R/W bit (0 write, 1 read), is acknowledged: `sdaOe` is high during the ninth clock, so the bus reads 0 at that clock's rising edge.
- R3: On an address mismatch, the slave does not acknowledge and keeps `sdaOe` low until the next START. Later bytes then leave the command outputs and both strobes unchanged.
- R4: Bits are sampled on rising SCL edges, MSB first. In the command byte, bit 7 is the leading 1, bits 6:4 are the channel, bit 3 is the span, bit 2 is polarity (1 bipolar) and bits 1:0 are the power-down mode. The outputs take the new command at its eighth bit, and the byte is acknowledged on the ninth clock.
- R5: After the write address acknowledge, 0 bits sent before the first 1 are skipped and raise no strobe.
- R6: `acqStart` pulses exactly once per command, for one clock. The pulse follows the sixth command bit (the polarity bit), and does not come after the fifth.
- R7: `convStart` pulses for one clock after a STOP that ends a write in which acquisition started. A STOP that ends a read, or a frame without a command, gives no pulse.
- R8: A read returns result[11:4] and then {result[3:0], 0000}, MSB first. The value is captured when the read address is accepted, so later changes to `result` do not affect that read.
- R9: The second read byte is sent whether the master acknowledges the first byte or not. After the second byte the slave releases SDA, so any further bytes read as FF.
- R10: A repeated START, even in the middle of a byte, restarts address reception.
- R11: `sdaOe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock as sampled from the pin |
| sdaIn | input | 1 | Bus data as sampled from the pin |
| addrStrap | input | 3 | Low three bits of the slave address |
| result | input | 12 | Latest conversion result from the core |
| sdaOe | output | 1 | 1 pulls SDA low (open-drain enable) |
| chanSel | output | 3 | Selected input channel |
| rangeHi | output | 1 | Span select, 1 for the wide span |
| bipolarSel | output | 1 | 1 for bipolar (two's complement) coding |
| pdMode | output | 2 | Power-down mode field |
| acqStart | output | 1 | One-clock pulse: start acquisition |
| convStart | output | 1 | One-clock pulse: hold and convert |

## Verification
The bench builds the block with its default parameters: a 12-bit result, two synchroniser stages and the 0101 address prefix. At these values both read bytes, including the four zero pad bits, appear at the port. SCL runs at one sixteenth of the system clock, which leaves several system clocks between a detected SCL edge and the opposite bus phase. With the straps drawn at random, all eight addresses are exercised. The leading-zero counts vary from none to three, so the self-framing of the command byte is checked at several offsets against the acquisition pulse.

// File: rtl/adc_cmd_pkg.sv
`timescale 1ns/1ps
package adc_cmd_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_CMD_WAIT, ST_CMD,
    ST_CMD_ACK, ST_WR_DONE, ST_TX, ST_TX_MACK, ST_RD_DONE
  } busState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftEn;
    logic shiftClr;
    logic capRes;
    logic loadCtrl;
    logic loadTx;
    logic txSel;
    logic txShift;
  } dpStrobe_t;

  typedef struct packed {
    logic [2:0] chan;
    logic       rangeHi;
    logic       bipolar;
    logic [1:0] pd;
  } ctrlWord_t;

endpackage

// File: rtl/adc_cmd_dp.sv
`timescale 1ns/1ps
module adc_cmd_dp
  import adc_cmd_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic             sdaBit,
  input  logic [RES_W-1:0] result,
  output logic [6:0]       addrBits,
  output logic             txBit,
  output ctrlWord_t        ctrl
);

  localparam int LO_W  = RES_W - 8;
  localparam int PAD_W = 8 - LO_W;

  logic [6:0]       shiftReg;
  logic [RES_W-1:0] resReg;
  logic [7:0]       txReg;
  ctrlWord_t        ctrlReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      resReg   <= '0;
      txReg    <= '0;
      ctrlReg  <= '0;
    end else begin
      if (strobe.shiftClr)     shiftReg <= '0;
      else if (strobe.shiftEn) shiftReg <= {shiftReg[5:0], sdaBit};
      if (strobe.capRes)       resReg   <= result;
      if (strobe.loadCtrl)     ctrlReg  <= {shiftReg[5:0], sdaBit};
      if (strobe.loadTx)
        txReg <= strobe.txSel ? {resReg[LO_W-1:0], {PAD_W{1'b0}}}
                              : resReg[RES_W-1 -: 8];
      else if (strobe.txShift) txReg <= {txReg[6:0], 1'b0};
    end
  end

  assign addrBits = shiftReg;
  assign txBit    = txReg[7];
  assign ctrl     = ctrlReg;

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadCtrl |=> $stable(ctrlReg)); // R4

  AST_TX_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadTx |-> !strobe.txShift); // R8

endmodule

// File: rtl/adc_cmd_ctrl.sv
`timescale 1ns/1ps
module adc_cmd_ctrl
  import adc_cmd_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] ADDR_HI     = 4'b0101
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] addrStrap,
  input  logic [6:0] addrBits,
  input  logic       txBit,
  output dpStrobe_t  strobe,
  output logic       sdaBit,
  output logic       sdaOe,
  output logic       acqStart,
  output logic       convStart
);

  localparam int PIPE_W = SYNC_STAGES + 1;

  logic [PIPE_W-1:0] sclPipe, sdaPipe;
  logic sclS, sclP, sdaS, sdaP;
  logic sclRise, sclFall, startDet, stopDet;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
    end else begin
      sclPipe <= {sclPipe[PIPE_W-2:0], sclIn};
      sdaPipe <= {sdaPipe[PIPE_W-2:0], sdaIn};
    end
  end

  assign sclS     = sclPipe[PIPE_W-2];
  assign sclP     = sclPipe[PIPE_W-1];
  assign sdaS     = sdaPipe[PIPE_W-2];
  assign sdaP     = sdaPipe[PIPE_W-1];
  assign sclRise  = sclS & ~sclP;
  assign sclFall  = ~sclS & sclP;
  assign startDet = sclS & sclP & sdaP & ~sdaS;
  assign stopDet  = sclS & sclP & ~sdaP & sdaS;

  busState_t state;
  logic [2:0] bitCnt;
  logic ackOn, rwRead, byteSel, acqActive;
  logic addrHit, lastBit;

  assign addrHit = (addrBits == {ADDR_HI, addrStrap});
  assign lastBit = (bitCnt == 3'd7);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      ackOn     <= 1'b0;
      rwRead    <= 1'b0;
      byteSel   <= 1'b0;
      acqActive <= 1'b0;
      acqStart  <= 1'b0;
      convStart <= 1'b0;
    end else begin
      acqStart  <= 1'b0;
      convStart <= 1'b0;
      if (startDet) begin
        state  <= ST_ADDR;
        bitCnt <= '0;
        ackOn  <= 1'b0;
      end else if (stopDet) begin
        state  <= ST_IDLE;
        ackOn  <= 1'b0;
        if (acqActive) begin
          convStart <= 1'b1;
          acqActive <= 1'b0;
        end
      end else begin
        unique case (state)
          ST_ADDR: if (sclRise) begin
            if (lastBit) begin
              bitCnt <= '0;
              rwRead <= sdaS;
              state  <= addrHit ? ST_ADDR_ACK : ST_IDLE;
            end else bitCnt <= bitCnt + 3'd1;
          end
          ST_ADDR_ACK: if (sclFall) begin
            if (!ackOn) ackOn <= 1'b1;
            else begin
              ackOn   <= 1'b0;
              bitCnt  <= '0;
              byteSel <= 1'b0;
              state   <= rwRead ? ST_TX : ST_CMD_WAIT;
            end
          end
          ST_CMD_WAIT: if (sclRise && sdaS) begin
            state  <= ST_CMD;
            bitCnt <= 3'd1;
          end
          ST_CMD: if (sclRise) begin
            if (bitCnt == 3'd5) begin
              acqStart  <= 1'b1;
              acqActive <= 1'b1;
            end
            if (lastBit) begin
              bitCnt <= '0;
              state  <= ST_CMD_ACK;
            end else bitCnt <= bitCnt + 3'd1;
          end
          ST_CMD_ACK: if (sclFall) begin
            if (!ackOn) ackOn <= 1'b1;
            else begin
              ackOn <= 1'b0;
              state <= ST_WR_DONE;
            end
          end
          ST_TX: if (sclFall) begin
            if (lastBit) begin
              bitCnt <= '0;
              state  <= ST_TX_MACK;
            end else bitCnt <= bitCnt + 3'd1;
          end
          ST_TX_MACK: if (sclFall) begin
            if (!byteSel) begin
              byteSel <= 1'b1;
              state   <= ST_TX;
            end else state <= ST_RD_DONE;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.shiftEn  = sclRise && (state == ST_ADDR || state == ST_CMD_WAIT || state == ST_CMD);
    strobe.shiftClr = startDet;
    strobe.capRes   = sclRise && state == ST_ADDR && lastBit && addrHit && sdaS;
    strobe.loadCtrl = sclRise && state == ST_CMD && lastBit;
    strobe.loadTx   = sclFall && ((state == ST_ADDR_ACK && ackOn && rwRead) ||
                                  (state == ST_TX_MACK && !byteSel));
    strobe.txSel    = (state == ST_TX_MACK);
    strobe.txShift  = sclFall && state == ST_TX;
  end

  assign sdaBit = sdaS;
  assign sdaOe  = ackOn || (state == ST_TX && !txBit);

  AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !sdaOe); // R3

  AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    ((sdaOe != $past(sdaOe)) && !$past(startDet) && !$past(stopDet)) |-> !sclS); // R11

  AST_ACQ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    acqStart |=> !acqStart); // R6

  AST_CONV_AFTER_STOP: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> $past(stopDet)); // R7

endmodule

// File: rtl/adc_cmd_slave.sv
`timescale 1ns/1ps
module adc_cmd_slave
  import adc_cmd_pkg::*;
#(
  parameter int         RES_W       = 12,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] ADDR_HI     = 4'b0101
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic [2:0]       addrStrap,
  input  logic [RES_W-1:0] result,
  output logic             sdaOe,
  output logic [2:0]       chanSel,
  output logic             rangeHi,
  output logic             bipolarSel,
  output logic [1:0]       pdMode,
  output logic             acqStart,
  output logic             convStart
);

  dpStrobe_t strobe;
  ctrlWord_t ctrl;
  logic [6:0] addrBits;
  logic txBit, sdaBit;

  adc_cmd_ctrl #(.SYNC_STAGES(SYNC_STAGES), .ADDR_HI(ADDR_HI)) ctrl_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .addrStrap(addrStrap), .addrBits(addrBits), .txBit(txBit),
    .strobe(strobe), .sdaBit(sdaBit), .sdaOe(sdaOe),
    .acqStart(acqStart), .convStart(convStart)
  );

  adc_cmd_dp #(.RES_W(RES_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sdaBit(sdaBit),
    .result(result), .addrBits(addrBits), .txBit(txBit), .ctrl(ctrl)
  );

  assign chanSel    = ctrl.chan;
  assign rangeHi    = ctrl.rangeHi;
  assign bipolarSel = ctrl.bipolar;
  assign pdMode     = ctrl.pd;

endmodule

// File: tb/adc_cmd_slave_tb_top.sv
`timescale 1ns/1ps
module adc_cmd_slave_tb_top;

  localparam logic [3:0] ADDR_HI = 4'b0101;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic [2:0] addrStrap = 3'd0;
  logic [11:0] result = 12'd0;
  logic sdaOe, rangeHi, bipolarSel, acqStart, convStart;
  logic [2:0] chanSel;
  logic [1:0] pdMode;
  logic sdaBus;

  int nChecks = 0, nErr = 0, acqCnt = 0, convCnt = 0, r11Bad = 0;
  logic prevOe = 1'b0;

  always #10 clk = ~clk;
  assign sdaBus = sdaM & ~sdaOe;

  adc_cmd_slave dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus),
    .addrStrap(addrStrap), .result(result), .sdaOe(sdaOe),
    .chanSel(chanSel), .rangeHi(rangeHi), .bipolarSel(bipolarSel),
    .pdMode(pdMode), .acqStart(acqStart), .convStart(convStart)
  );

  always @(posedge clk) begin
    if (acqStart)  acqCnt++;
    if (convStart) convCnt++;
  end

  // R11 monitor at the pins
  always @(negedge clk) begin
    if (rstN && sclM && (sdaOe !== prevOe)) r11Bad++;
    prevOe = sdaOe;
  end

  task automatic chkEq(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] hiByte(input logic [11:0] r);
    return r[11:4];
  endfunction
  function automatic logic [7:0] loByte(input logic [11:0] r);
    return {r[3:0], 4'b0000};
  endfunction

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sclBit(input logic b, output logic busVal);
    sclM = 1'b0; waitCyc(2);
    sdaM = b;    waitCyc(6);
    sclM = 1'b1; waitCyc(4);
    busVal = sdaBus; waitCyc(4);
  endtask

  task automatic startCond;
    sclM = 1'b0; waitCyc(2);
    sdaM = 1'b1; waitCyc(4);
    sclM = 1'b1; waitCyc(4);
    sdaM = 1'b0; waitCyc(4);
  endtask

  task automatic stopCond;
    sclM = 1'b0; waitCyc(2);
    sdaM = 1'b0; waitCyc(4);
    sclM = 1'b1; waitCyc(4);
    sdaM = 1'b1; waitCyc(6);
  endtask

  task automatic sendByte(input logic [7:0] d, output logic acked);
    logic bus;
    for (int i = 7; i >= 0; i--) sclBit(d[i], bus);
    sclBit(1'b1, bus);
    acked = ~bus;
  endtask

  task automatic readByte(input logic mAck, output logic [7:0] d);
    logic bus;
    for (int i = 7; i >= 0; i--) begin
      sclBit(1'b1, bus);
      d[i] = bus;
    end
    sclBit(~mAck, bus);
  endtask

  task automatic doWrite(input logic [2:0] strap, input logic [6:0] body, input int zeros);
    logic ack, bus;
    logic [7:0] cb;
    int acq0, conv0;
    cb = {1'b1, body};
    addrStrap = strap;
    startCond;
    acq0 = acqCnt; conv0 = convCnt;
    sendByte({ADDR_HI, strap, 1'b0}, ack);
    chkEq("R2 write address ack", ack, 1);
    for (int z = 0; z < zeros; z++) sclBit(1'b0, bus);
    chkEq("R5 leading zeros skipped", acqCnt, acq0);
    for (int i = 7; i >= 0; i--) begin
      sclBit(cb[i], bus);
      if (i == 3) chkEq("R6 no acq after fifth bit", acqCnt, acq0);
      if (i == 2) chkEq("R6 acq after sixth bit", acqCnt, acq0 + 1);
    end
    sclBit(1'b1, bus);
    chkEq("R4 command ack", bus, 0);
    chkEq("R4 channel", chanSel, body[6:4]);
    chkEq("R4 span", rangeHi, body[3]);
    chkEq("R4 polarity", bipolarSel, body[2]);
    chkEq("R4 power-down", pdMode, body[1:0]);
    stopCond;
    chkEq("R7 conversion on STOP", convCnt, conv0 + 1);
    chkEq("R6 single acq pulse", acqCnt, acq0 + 1);
  endtask

  task automatic doRead(input logic [2:0] strap, input logic [11:0] res,
                        input logic [11:0] resAfter, input logic mAck1, input bit extra);
    logic ack;
    logic [7:0] b1, b2, b3;
    int conv0;
    addrStrap = strap;
    result = res;
    startCond;
    conv0 = convCnt;
    sendByte({ADDR_HI, strap, 1'b1}, ack);
    chkEq("R2 read address ack", ack, 1);
    result = resAfter;
    readByte(mAck1, b1);
    readByte(1'b0, b2);
    chkEq("R8 first read byte", b1, hiByte(res));
    chkEq("R9 second byte regardless of master ack", b2, loByte(res));
    if (extra) begin
      readByte(1'b0, b3);
      chkEq("R9 released after second byte", b3, 8'hFF);
    end
    stopCond;
    chkEq("R7 no conversion after read", convCnt, conv0);
  endtask

  initial begin
    logic ack, bus;
    void'($urandom(32'h5eed));
    waitCyc(5);
    chkEq("R1 sdaOe after reset", sdaOe, 0);
    chkEq("R1 command outputs after reset", {chanSel, rangeHi, bipolarSel, pdMode}, 0);
    chkEq("R1 no strobes in reset", acqCnt + convCnt, 0);
    rstN = 1'b1;
    waitCyc(5);
    chkEq("R1 sdaOe idle", sdaOe, 0);

    // directed write
    doWrite(3'b101, 7'b110_1_1_10, 2);

    // random writes and reads
    for (int k = 0; k < 8; k++) begin
      logic [2:0] s;
      logic [6:0] body;
      logic [11:0] r;
      s = 3'($urandom);
      body = 7'($urandom);
      r = 12'($urandom);
      doWrite(s, body, int'($urandom % 4));
      doRead(s, r, r, 1'($urandom), 1'b0);
    end

    // R8 capture at address accept, R9 NACK on first byte and released tail
    doRead(3'b011, 12'hA5C, 12'h3F0, 1'b0, 1'b1);
    doRead(3'b000, 12'h001, 12'hFFF, 1'b1, 1'b1);

    // R3 address mismatch
    begin
      int acq0, conv0;
      logic [2:0] c0;
      addrStrap = 3'b010;
      c0 = chanSel;
      acq0 = acqCnt; conv0 = convCnt;
      startCond;
      sendByte({ADDR_HI, 3'b011, 1'b0}, ack);
      chkEq("R3 mismatch not acked", ack, 0);
      sendByte(8'b1111_0111, ack);
      chkEq("R3 later byte not acked", ack, 0);
      chkEq("R3 outputs unchanged", chanSel, c0);
      chkEq("R3 no acq after mismatch", acqCnt, acq0);
      stopCond;
      chkEq("R3 no conversion after mismatch", convCnt, conv0);
    end

    // R10 repeated START mid-byte
    begin
      addrStrap = 3'b110;
      startCond;
      sclBit(1'b1, bus); sclBit(1'b1, bus); sclBit(1'b0, bus);
      startCond;
      sendByte({ADDR_HI, 3'b110, 1'b0}, ack);
      chkEq("R10 address after repeated START", ack, 1);
      sendByte(8'b1011_0101, ack);
      chkEq("R10 command acked", ack, 1);
      chkEq("R10 channel taken", chanSel, 3'b011);
      stopCond;
    end

    // R7 STOP without command
    begin
      int conv0;
      conv0 = convCnt;
      addrStrap = 3'b001;
      startCond;
      sendByte({ADDR_HI, 3'b001, 1'b0}, ack);
      stopCond;
      chkEq("R7 no conversion without command", convCnt, conv0);
    end

    chkEq("R11 sdaOe changed with SCL high", r11Bad, 0);
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nErr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

endmodule